// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

The controller watches five hardware request lines and, at the close of each instruction, picks the most urgent one that is allowed to run. It then presents a 16-bit service address for that request. One line cannot be masked and needs a rising edge followed by a held level. One vectored maskable line reacts only to a low-to-high transition, which it keeps in a latch until that request is serviced. Two vectored maskable lines are level sensitive. One maskable line has no fixed vector: when it is chosen, the block raises its acknowledge and passes through a service address that external logic supplies.

Software controls the block through a single write port. That port loads four mask bits and a global enable. Every interrupt taken clears the enable, and software must set it again before another maskable request can be served. A one-hot acknowledge pulse tells the core which source won, and the service address is valid during that same cycle.

Top module: `pvic_top`

## Requirements
- R1: Priority, from highest to lowest, is: non-maskable, edge line, upper level line, lower level line, external line. The one-hot `ack_o` shows the winner with bit 0 = non-maskable, bit 1 = edge, bit 2 = upper level, bit 3 = lower level and bit 4 = external.
- R2: When a vectored source is acknowledged, `svc_addr_o` holds its fixed address: 0x0024 for non-maskable, 0x003C for edge, 0x0034 for upper level and 0x002C for lower level. When `ack_o` is zero, `svc_addr_o` is 0x0000.
- R3: When the external line is acknowledged, `ack_o[4]` is high and `svc_addr_o` equals `ext_vector_i` during that cycle.
- R4: A low-to-high transition on the edge line sets a latch. The latch holds through cycles where the line is masked, the enable is off, or no instruction ends, and it clears only when the edge line is serviced. A line that simply stays high raises no new request.
- R5: The non-maskable line is served only after a rising edge, and only if the line is still high in the cycle `insn_done_i` is high. If the line falls first, the request is dropped. Mask bits and the global enable have no effect on this line.
- R6: The two level lines and the external line request only while they are high. A pulse that ends before the instruction ends is not served.
- R7: A `mask_wr_i` pulse loads `mask_wdata_i` and `ien_wdata_i` for the following cycles. Mask bit 0 blocks the edge line, bit 1 the upper level line, bit 2 the lower level line and bit 3 the external line, with 1 meaning blocked. Maskable sources need the enable to be 1.
- R8: A request is taken only in a cycle where `insn_done_i` is high. The acknowledge is a single-cycle pulse in the next cycle, with at most one bit set.
- R9: Taking any interrupt clears the global enable. This clear wins over an enable written in the same cycle.
- R10: After reset: mask = 0b1111, enable = 0, `ack_o` = 0, `svc_addr_o` = 0. Both edge detectors treat their lines as already high, so a line held high across reset produces no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_nmi_i | input | 1 | Non-maskable request, edge plus level |
| irq_edge_i | input | 1 | Maskable vectored request, rising edge |
| irq_lvl_hi_i | input | 1 | Maskable vectored request, level, upper |
| irq_lvl_lo_i | input | 1 | Maskable vectored request, level, lower |
| irq_ext_i | input | 1 | Maskable request with external vector |
| mask_wr_i | input | 1 | Write strobe for mask and enable |
| mask_wdata_i | input | 4 | Mask bits, 1 = blocked |
| ien_wdata_i | input | 1 | Global enable value to write |
| insn_done_i | input | 1 | End-of-instruction strobe |
| ext_vector_i | input | 16 | Service address for the external source |
| ack_o | output | 5 | One-hot acknowledge of the source taken |
| svc_addr_o | output | 16 | Service address of the acknowledged source |

## Verification
The bench uses the default build: five sources and 16-bit addresses. That small size lets it sweep every combination of the five line states, all sixteen mask patterns and both enable values. For each combination it checks three takes in a row: the first winner, the silence that follows once the enable clears, and the second winner after the enable is restored. That second take also shows whether the edge latch survived losing to a higher source. Directed sequences cover edge handling across reset, short pulses, and the enable write that collides with a take.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
    localparam int NUM_SRC  = 5;
    localparam int NUM_MASK = NUM_SRC - 1;
    localparam int ADDR_W   = 16;
    localparam int IDX_W    = $clog2(NUM_SRC);

    localparam int SRC_NMI  = 0;
    localparam int SRC_EDGE = 1;
    localparam int SRC_HI   = 2;
    localparam int SRC_LO   = 3;
    localparam int SRC_EXT  = 4;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    function automatic logic [ADDR_W-1:0] fixed_vector(input logic [IDX_W-1:0] idx);
        case (idx)
            IDX_W'(SRC_NMI):  return ADDR_W'(16'h0024);
            IDX_W'(SRC_EDGE): return ADDR_W'(16'h003C);
            IDX_W'(SRC_HI):   return ADDR_W'(16'h0034);
            IDX_W'(SRC_LO):   return ADDR_W'(16'h002C);
            default:          return '0;
        endcase
    endfunction
endpackage

// File: rtl/pvic_trig.sv
module pvic_trig (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic nmi_i,
    input  logic edge_i,
    input  logic svc_nmi_i,
    input  logic svc_edge_i,
    output logic nmi_req_o,
    output logic edge_req_o
);
    typedef struct packed {
        logic nmi_prev;
        logic edge_prev;
        logic nmi_pend;
        logic edge_pend;
    } trig_t;

    trig_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        nmi_req_o  = nmi_i & (st_q.nmi_pend | ~st_q.nmi_prev);
        edge_req_o = st_q.edge_pend | (edge_i & ~st_q.edge_prev);
        st_d.nmi_prev  = nmi_i;
        st_d.edge_prev = edge_i;
        st_d.nmi_pend  = nmi_req_o & ~svc_nmi_i;
        st_d.edge_pend = edge_req_o & ~svc_edge_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{nmi_prev: 1'b1, edge_prev: 1'b1, nmi_pend: 1'b0, edge_pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o
);
    always_comb begin
        logic found;
        found   = 1'b0;
        grant_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !found) begin
                grant_o[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
    import pvic_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                irq_nmi_i,
    input  logic                irq_edge_i,
    input  logic                irq_lvl_hi_i,
    input  logic                irq_lvl_lo_i,
    input  logic                irq_ext_i,
    input  logic                mask_wr_i,
    input  logic [3:0]          mask_wdata_i,
    input  logic                ien_wdata_i,
    input  logic                insn_done_i,
    input  logic [15:0]         ext_vector_i,
    output logic [4:0]          ack_o,
    output logic [15:0]         svc_addr_o
);
    typedef struct packed {
        logic [NUM_MASK-1:0] mask;
        logic                ien;
        src_vec_t            ack;
        logic [ADDR_W-1:0]   vec;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic     nmi_req, edge_req, take;
    src_vec_t req, grant, svc;
    logic [NUM_MASK-1:0] allow;
    logic [NUM_MASK-1:0] mask_lines;

    assign mask_lines = {irq_ext_i, irq_lvl_lo_i, irq_lvl_hi_i, edge_req};

    pvic_trig trig_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .nmi_i      (irq_nmi_i),
        .edge_i     (irq_edge_i),
        .svc_nmi_i  (svc[SRC_NMI]),
        .svc_edge_i (svc[SRC_EDGE]),
        .nmi_req_o  (nmi_req),
        .edge_req_o (edge_req)
    );

    pvic_arb #(.N(NUM_SRC)) arb_i (
        .req_i   (req),
        .grant_o (grant)
    );

    always_comb begin
        allow = ~ctl_q.mask & {NUM_MASK{ctl_q.ien}};
        req   = {mask_lines & allow, nmi_req};
        take  = insn_done_i & (|req);
        svc   = take ? grant : '0;

        ctl_d     = ctl_q;
        ctl_d.ack = svc;
        ctl_d.vec = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (svc[i]) begin
                ctl_d.vec = fixed_vector(IDX_W'(i));
            end
        end
        if (mask_wr_i) begin
            ctl_d.mask = mask_wdata_i;
            ctl_d.ien  = ien_wdata_i;
        end
        if (take) begin
            ctl_d.ien = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q <= '{mask: '1, ien: 1'b0, ack: '0, vec: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ack_o      = ctl_q.ack;
    assign svc_addr_o = ctl_q.ack[SRC_EXT] ? ext_vector_i : ctl_q.vec;
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        irq_nmi_i,
    input logic        irq_lvl_hi_i,
    input logic        irq_lvl_lo_i,
    input logic        irq_ext_i,
    input logic        insn_done_i,
    input logic [15:0] ext_vector_i,
    input logic [4:0]  ack_o,
    input logic [15:0] svc_addr_o
);
    // R8: at most one source acknowledged
    a_r8_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(ack_o));
    // R8: a take needs the end-of-instruction strobe one cycle earlier
    a_r8_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_o != 5'd0) |-> $past(insn_done_i));
    // R8 / R9: acknowledge lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_o != 5'd0) |=> (ack_o == 5'd0));
    // R5: non-maskable line high when taken
    a_r5_nmi_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o[0] |-> $past(irq_nmi_i));
    // R6: level lines high when taken
    a_r6_hi_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o[2] |-> $past(irq_lvl_hi_i));
    a_r6_lo_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o[3] |-> $past(irq_lvl_lo_i));
    // R3: external source forwards its address
    a_r3_ext_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o[4] |-> (svc_addr_o == ext_vector_i) && $past(irq_ext_i));
    // R2: fixed address of the edge source
    a_r2_edge_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o[1] |-> (svc_addr_o == 16'h003C));
    // R2: idle address is zero
    a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_o == 5'd0) |-> (svc_addr_o == 16'h0000));
endmodule

bind pvic_top pvic_chk chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_nmi_i    (irq_nmi_i),
    .irq_lvl_hi_i (irq_lvl_hi_i),
    .irq_lvl_lo_i (irq_lvl_lo_i),
    .irq_ext_i    (irq_ext_i),
    .insn_done_i  (insn_done_i),
    .ext_vector_i (ext_vector_i),
    .ack_o        (ack_o),
    .svc_addr_o   (svc_addr_o)
);

// File: tb/pvic_top_tb_top.sv
module pvic_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  lines = '0;
    logic        mask_wr = 1'b0;
    logic [3:0]  mask_wdata = '0;
    logic        ien_wdata = 1'b0;
    logic        insn_done = 1'b0;
    logic [15:0] ext_vector = '0;
    logic [4:0]  ack;
    logic [15:0] svc_addr;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pvic_top dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .irq_nmi_i    (lines[0]),
        .irq_edge_i   (lines[1]),
        .irq_lvl_hi_i (lines[2]),
        .irq_lvl_lo_i (lines[3]),
        .irq_ext_i    (lines[4]),
        .mask_wr_i    (mask_wr),
        .mask_wdata_i (mask_wdata),
        .ien_wdata_i  (ien_wdata),
        .insn_done_i  (insn_done),
        .ext_vector_i (ext_vector),
        .ack_o        (ack),
        .svc_addr_o   (svc_addr)
    );

    function automatic int pick(input logic [4:0] c);
        for (int i = 0; i < 5; i++) if (c[i]) return i;
        return -1;
    endfunction

    function automatic logic [15:0] addr_of(input int w, input logic [15:0] ev);
        case (w)
            0: return 16'h0024;
            1: return 16'h003C;
            2: return 16'h0034;
            3: return 16'h002C;
            4: return ev;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input int w);
        logic [4:0]  ea;
        logic [15:0] ed;
        ea = (w < 0) ? 5'd0 : 5'(1 << w);
        ed = addr_of(w, ext_vector);
        checks++;
        if (ack !== ea || svc_addr !== ed) begin
            errors++;
            $display("FAIL %s ack=%b addr=%h expected ack=%b addr=%h", tag, ack, svc_addr, ea, ed);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        insn_done = 1'b0;
        mask_wr = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic write_ctl(input logic [3:0] m, input logic e);
        mask_wr = 1'b1; mask_wdata = m; ien_wdata = e;
        tick();
        mask_wr = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        // R10: reset state
        lines = '0;
        do_reset();
        check("R10 reset", -1);

        // R10 / R4 / R5: lines held high across reset give no edge
        lines = 5'b00011;
        do_reset();
        write_ctl(4'b0000, 1'b1);
        insn_done = 1'b1; tick(); insn_done = 1'b0;
        check("R4 no edge after reset", -1);
        check("R10 no edge after reset", -1);

        // R5: short non-maskable pulse is dropped
        lines = '0;
        do_reset();
        tick();
        lines[0] = 1'b1; tick();
        lines[0] = 1'b0; tick();
        insn_done = 1'b1; tick(); insn_done = 1'b0;
        check("R5 pulse dropped", -1);
        // R5: taken despite reset mask and disabled enable
        lines[0] = 1'b1; insn_done = 1'b1; tick(); insn_done = 1'b0;
        check("R5 ignores mask", 0);
        lines = '0;

        // R6: level pulse not held is not served
        do_reset();
        write_ctl(4'b0000, 1'b1);
        lines[3] = 1'b1; tick();
        lines[3] = 1'b0; tick();
        insn_done = 1'b1; tick(); insn_done = 1'b0;
        check("R6 level pulse", -1);

        // R9: take clears enable over a same-cycle write
        lines[3] = 1'b1; insn_done = 1'b1;
        mask_wr = 1'b1; mask_wdata = 4'b0000; ien_wdata = 1'b1;
        tick();
        mask_wr = 1'b0;
        check("R9 take", 3);
        tick();
        check("R9 still idle", -1);
        insn_done = 1'b0;
        lines = '0;

        // Sweep: R1 R2 R3 R4 R7 R8 R9
        for (int p = 0; p < 32; p++) begin
            for (int m = 0; m < 16; m++) begin
                for (int e = 0; e < 2; e++) begin
                    logic [4:0] pv, mv, c;
                    int w1, w3;
                    pv = 5'(p); mv = {1'b0, 4'(m)};
                    ext_vector = 16'hC000 | 16'(p * 32 + m * 2 + e);
                    lines = '0;
                    do_reset();
                    write_ctl(4'(m), 1'(e));
                    lines = pv; insn_done = 1'b0; tick();
                    check("R8 no done", -1);
                    c[0] = pv[0];
                    for (int k = 1; k < 5; k++) c[k] = pv[k] & ~mv[k-1] & 1'(e);
                    w1 = pick(c);
                    insn_done = 1'b1; tick(); insn_done = 1'b0;
                    check("R1 R2 R3 R7 first", w1);
                    insn_done = 1'b1; tick(); insn_done = 1'b0;
                    check("R9 enable cleared", (w1 < 0 && e == 1) ? -1 : ((w1 < 0) ? -1 : -1));
                    write_ctl(4'(m), 1'b1);
                    c[0] = 1'b0;
                    c[1] = pv[1] & ~mv[0] & (w1 != 1);
                    for (int k = 2; k < 5; k++) c[k] = pv[k] & ~mv[k-1];
                    w3 = pick(c);
                    insn_done = 1'b1; tick(); insn_done = 1'b0;
                    check("R4 R1 second", w3);
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule